// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a 32-bit RISC core fetches next. It takes the address of the current instruction, the decoded instruction word, two register operands, the address saved when an interrupt was entered, and a strobe that signals a return from interrupt. From these it produces the next fetch address and a flag that says whether control flow left the sequential path.

The block is purely combinational. Branch comparisons are done inside it, in both signed and unsigned forms. The block covers these cases:
- absolute and PC-relative jumps;
- jumps through a register plus an offset;
- compare-and-branch;
- halt;
- interrupt return.

All other instruction classes fall through to the next word address. Addresses count words, and every sum wraps modulo 2^32.

Top module: `nxtpc_unit`

## Requirements
- R1: The class field is instr[31:28]. Every class other than 1111, 1001, 1000, 0110 and 0100 gives next_pc = pc+1 and taken = 0, provided reti_stb_i is low.
- R2: Class 1001 with instr[0]=0 loads next_pc with the zero-extended 27-bit constant held in instr[27:1].
- R3: Class 1001 with instr[0]=1 sets next_pc to pc plus that 27-bit constant sign-extended from bit 26.
- R4: Class 1000 with instr[0]=0 sets next_pc to opb plus the sign-extended 16-bit constant in instr[27:12].
- R5: Class 1000 with instr[0]=1 sets next_pc to pc + opb + the sign-extended 16-bit constant in instr[27:12].
- R6: For class 0110, the condition in instr[3:1] compares opa with opb as follows: 000 equal, 001 greater, 010 greater-or-equal, 100 not-equal, 101 less, 110 less-or-equal. When instr[0]=0 the compare is unsigned.
- R7: For class 0110 with instr[0]=1, the greater/less conditions treat both operands as two's-complement numbers.
- R8: For class 0110, the condition codes 011 and 111 are never taken, so next_pc = pc+1 and taken = 0.
- R9: A branch whose condition holds gives next_pc = pc + the sign-extended instr[27:12]. A branch whose condition fails gives pc+1.
- R10: Class 1111 keeps next_pc equal to pc, with taken = 1.
- R11: Class 0100, or reti_stb_i high, gives next_pc = irq_pc_i. The strobe overrides any class.
- R12: taken is 1 exactly for these cases: jump, register jump, halt, return, and a branch whose condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Word address of the current instruction |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | First register operand (branch left side) |
| opb_i | input | 32 | Second register operand (branch right side, jump base) |
| irq_pc_i | input | 32 | Address saved at interrupt entry |
| reti_stb_i | input | 1 | Interrupt-return strobe |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Non-sequential flow indicator |

## Verification
The block holds no state, so any wrong internal decision shows up at next_pc_o and taken_o in the same evaluation as the inputs. The likely faults are these:
- a flipped signed/unsigned selection;
- a swapped condition code;
- a truncated sign extension.

Each of them gives a target that is off by the offset, or a taken flag that disagrees with the compare. The bench therefore sweeps every condition code and both signedness settings over operands that straddle the sign boundary. It also drives offsets of both signs.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;
  localparam int XLEN   = 32;
  localparam int OFF_W  = 16;
  localparam int JOFF_W = 27;

  typedef enum logic [3:0] {
    CLS_HALT   = 4'b1111,
    CLS_JUMP   = 4'b1001,
    CLS_JUMPR  = 4'b1000,
    CLS_BRANCH = 4'b0110,
    CLS_RETI   = 4'b0100
  } pc_class_e;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_GT  = 3'b001,
    CND_GE  = 3'b010,
    CND_R3  = 3'b011,
    CND_NE  = 3'b100,
    CND_LT  = 3'b101,
    CND_LE  = 3'b110,
    CND_R7  = 3'b111
  } br_cond_e;

  function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] v);
    return {{(XLEN-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_joff(input logic [JOFF_W-1:0] v);
    return {{(XLEN-JOFF_W){v[JOFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_joff(input logic [JOFF_W-1:0] v);
    return {{(XLEN-JOFF_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/nxtpc_cmp.sv
module nxtpc_cmp
  import nxtpc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   cond_i,
  input  logic         sgn_i,
  output logic         hit_o,
  output logic         rsvd_o
);
  logic [W-1:0] a_bias, b_bias;
  logic         eq, lt;

  // Flipping the sign bit maps signed order onto unsigned order.
  assign a_bias = {a_i[W-1] ^ sgn_i, a_i[W-2:0]};
  assign b_bias = {b_i[W-1] ^ sgn_i, b_i[W-2:0]};
  assign eq     = (a_i == b_i);
  assign lt     = (a_bias < b_bias);

  always_comb begin
    hit_o  = 1'b0;
    rsvd_o = 1'b0;
    unique case (br_cond_e'(cond_i))
      CND_EQ: hit_o = eq;
      CND_GT: hit_o = !lt && !eq;
      CND_GE: hit_o = !lt;
      CND_NE: hit_o = !eq;
      CND_LT: hit_o = lt;
      CND_LE: hit_o = lt || eq;
      CND_R3, CND_R7: rsvd_o = 1'b1;
      default: rsvd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nxtpc_tgt.sv
module nxtpc_tgt
  import nxtpc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]  pc_i,
  input  logic [31:0]   instr_i,
  input  logic [W-1:0]  opb_i,
  output logic [W-1:0]  seq_o,
  output logic [W-1:0]  jmp_o,
  output logic [W-1:0]  jreg_o,
  output logic [W-1:0]  br_o
);
  logic          rel;
  logic [W-1:0]  off16;
  logic [W-1:0]  base_reg;

  assign rel      = instr_i[0];
  assign off16    = sext_off(instr_i[27:12]);
  assign base_reg = opb_i + off16;

  assign seq_o  = pc_i + W'(1);
  assign br_o   = pc_i + off16;
  assign jmp_o  = rel ? (pc_i + sext_joff(instr_i[27:1])) : zext_joff(instr_i[27:1]);
  assign jreg_o = rel ? (pc_i + base_reg) : base_reg;
endmodule

// File: rtl/nxtpc_unit.sv
module nxtpc_unit
  import nxtpc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]  pc_i,
  input  logic [31:0]   instr_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic [W-1:0]  irq_pc_i,
  input  logic          reti_stb_i,
  output logic [W-1:0]  next_pc_o,
  output logic          taken_o
);
  pc_class_e    cls;
  logic         is_halt, is_jump, is_jreg, is_branch, is_ret;
  logic         br_hit, br_rsvd;
  logic [W-1:0] seq_pc, jmp_tgt, jreg_tgt, br_tgt;

  assign cls       = pc_class_e'(instr_i[31:28]);
  assign is_ret    = reti_stb_i || (cls == CLS_RETI);
  assign is_halt   = !is_ret && (cls == CLS_HALT);
  assign is_jump   = !is_ret && (cls == CLS_JUMP);
  assign is_jreg   = !is_ret && (cls == CLS_JUMPR);
  assign is_branch = !is_ret && (cls == CLS_BRANCH);

  nxtpc_cmp #(.W(W)) u_cmp (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .cond_i (instr_i[3:1]),
    .sgn_i  (instr_i[0]),
    .hit_o  (br_hit),
    .rsvd_o (br_rsvd)
  );

  nxtpc_tgt #(.W(W)) u_tgt (
    .pc_i    (pc_i),
    .instr_i (instr_i),
    .opb_i   (opb_i),
    .seq_o   (seq_pc),
    .jmp_o   (jmp_tgt),
    .jreg_o  (jreg_tgt),
    .br_o    (br_tgt)
  );

  always_comb begin
    next_pc_o = seq_pc;
    taken_o   = 1'b0;
    if (is_ret) begin
      next_pc_o = irq_pc_i;
      taken_o   = 1'b1;
    end else if (is_halt) begin
      next_pc_o = pc_i;
      taken_o   = 1'b1;
    end else if (is_jump) begin
      next_pc_o = jmp_tgt;
      taken_o   = 1'b1;
    end else if (is_jreg) begin
      next_pc_o = jreg_tgt;
      taken_o   = 1'b1;
    end else if (is_branch && br_hit) begin
      next_pc_o = br_tgt;
      taken_o   = 1'b1;
    end
  end
endmodule

// File: rtl/nxtpc_unit_chk.sv
module nxtpc_unit_chk
  import nxtpc_pkg::*;
#(
  parameter int W = XLEN
) (
  input logic [W-1:0] pc_i,
  input logic [31:0]  instr_i,
  input logic [W-1:0] irq_pc_i,
  input logic         reti_stb_i,
  input logic [W-1:0] next_pc_o,
  input logic         taken_o,
  input logic         is_halt,
  input logic         is_branch,
  input logic         br_hit,
  input logic         br_rsvd
);
  always_comb begin
    AST_RETI_RESTORE: assert (!reti_stb_i || (next_pc_o == irq_pc_i && taken_o)); // R11
    AST_HALT_HOLD: assert (!is_halt || next_pc_o == pc_i); // R10
    AST_SEQ_WHEN_NOT_TAKEN: assert (taken_o || next_pc_o == pc_i + W'(1)); // R1
    AST_RSVD_NEVER_TAKEN: assert (!(is_branch && br_rsvd) || !taken_o); // R8
    AST_RSVD_NO_HIT: assert (!br_rsvd || !br_hit); // R8
    AST_BRANCH_TARGET: assert (!(is_branch && taken_o) || next_pc_o == pc_i + sext_off(instr_i[27:12])); // R9
  end
endmodule

bind nxtpc_unit nxtpc_unit_chk #(.W(W)) u_chk (
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .irq_pc_i   (irq_pc_i),
  .reti_stb_i (reti_stb_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .is_halt    (is_halt),
  .is_branch  (is_branch),
  .br_hit     (br_hit),
  .br_rsvd    (br_rsvd)
);

// File: tb/nxtpc_unit_tb.sv
module nxtpc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] pc, instr, opa, opb, irq_pc;
  logic        stb;
  logic [31:0] next_pc;
  logic        taken;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nxtpc_unit u_dut (
    .pc_i       (pc),
    .instr_i    (instr),
    .opa_i      (opa),
    .opb_i      (opb),
    .irq_pc_i   (irq_pc),
    .reti_stb_i (stb),
    .next_pc_o  (next_pc),
    .taken_o    (taken)
  );

  function automatic bit ref_cond(input logic [2:0] c, input bit s, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = s ? longint'($signed(a)) : longint'({32'h0, a});
    sb = s ? longint'($signed(b)) : longint'({32'h0, b});
    case (c)
      3'd0: return sa == sb;
      3'd1: return sa > sb;
      3'd2: return sa >= sb;
      3'd4: return sa != sb;
      3'd5: return sa < sb;
      3'd6: return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] off16(input logic [15:0] o);
    return 32'($signed(o));
  endfunction

  task automatic apply(input logic [31:0] p, input logic [31:0] i, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] ip, input logic s,
                       input logic [31:0] exp_pc, input logic exp_tk, input string tag);
    @(negedge clk);
    pc = p; instr = i; opa = a; opb = b; irq_pc = ip; stb = s;
    #(CLK_PERIOD/4);
    n_chk++;
    if (next_pc !== exp_pc || taken !== exp_tk) begin
      n_bad++;
      $display("FAIL %s: instr=%h a=%h b=%h got pc=%h tk=%b exp pc=%h tk=%b",
               tag, i, a, b, next_pc, taken, exp_pc, exp_tk);
    end
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [15:0] offs [3];
    vals = '{32'h0, 32'h1, 32'h5, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff};
    offs = '{16'h0010, 16'hfff0, 16'h8000};
    pc = '0; instr = '0; opa = '0; opb = '0; irq_pc = '0; stb = 1'b0;

    // R1 reset-like idle state: all zero inputs -> pc+1
    apply(32'h0, 32'h0, 0, 0, 0, 0, 32'h1, 0, "R1 idle");
    // R1 sweep over non-control classes, including wrap
    for (int c = 0; c < 16; c++) begin
      if (c == 15 || c == 9 || c == 8 || c == 6 || c == 4) continue;
      apply(32'h1234, {4'(c), 28'hfff_ffff}, 7, 9, 32'h55, 0, 32'h1235, 0, "R1 seq");
      apply(32'hffff_ffff, {4'(c), 28'h0}, 0, 0, 0, 0, 32'h0, 0, "R1 wrap");
    end
    // R2 absolute jump, R3 relative jump
    apply(32'h100, {4'b1001, 27'h7ff_ffff, 1'b0}, 0, 0, 0, 0, 32'h07ff_ffff, 1, "R2 abs max");
    apply(32'h100, {4'b1001, 27'h000_0040, 1'b0}, 0, 0, 0, 0, 32'h40, 1, "R2 abs");
    apply(32'h100, {4'b1001, 27'h000_0040, 1'b1}, 0, 0, 0, 0, 32'h140, 1, "R3 rel fwd");
    apply(32'h100, {4'b1001, 27'h7ff_ffff, 1'b1}, 0, 0, 0, 0, 32'hff, 1, "R3 rel back");
    apply(32'h100, {4'b1001, 27'h400_0000, 1'b1}, 0, 0, 0, 0, 32'h100 - 32'h0400_0000, 1, "R3 rel min");
    // R4 / R5 register jumps with both offset signs
    foreach (offs[k]) begin
      apply(32'h2000, {4'b1000, offs[k], 11'h0, 1'b0}, 0, 32'h9000, 0, 0,
            32'h9000 + off16(offs[k]), 1, "R4 jreg abs");
      apply(32'h2000, {4'b1000, offs[k], 11'h0, 1'b1}, 0, 32'h9000, 0, 0,
            32'h2000 + 32'h9000 + off16(offs[k]), 1, "R5 jreg rel");
    end
    // R6 R7 R8 R9 R12: all conditions, both signs, operand pairs
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        foreach (vals[x])
          foreach (vals[y]) begin
            bit h;
            logic [15:0] o;
            o = offs[(x + y) % 3];
            h = ref_cond(3'(c), s[0], vals[x], vals[y]);
            apply(32'h8000, {4'b0110, o, 8'h0, 3'(c), s[0]}, vals[x], vals[y], 0, 0,
                  h ? 32'h8000 + off16(o) : 32'h8001, h,
                  (c == 3 || c == 7) ? "R8 rsvd" : (s != 0 ? "R7 signed R9 R12" : "R6 unsigned R9 R12"));
          end
    // R10 halt
    apply(32'h3333, 32'hffff_ffff, 0, 0, 32'h77, 0, 32'h3333, 1, "R10 halt");
    apply(32'h0, 32'hf000_0000, 0, 0, 0, 0, 32'h0, 1, "R10 halt zero");
    // R11 interrupt return: class and strobe, strobe overrides others
    apply(32'h10, 32'h4000_0000, 0, 0, 32'habcd, 0, 32'habcd, 1, "R11 reti class");
    apply(32'h10, 32'h0000_0000, 0, 0, 32'h1111, 1, 32'h1111, 1, "R11 strobe");
    apply(32'h10, 32'hffff_ffff, 0, 0, 32'h2222, 1, 32'h2222, 1, "R11 over halt");
    apply(32'h10, {4'b1001, 27'h5, 1'b0}, 0, 0, 32'h3333, 1, 32'h3333, 1, "R11 over jump");
    apply(32'h10, {4'b0110, 16'h4, 8'h0, 3'd0, 1'b0}, 3, 3, 32'h4444, 1, 32'h4444, 1, "R11 over branch");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule